// File: doc/BRIEF.md
# Dual-Side Mailbox Channel Unit

This block passes short 32-bit messages between a local processing core and a host. The core reaches the block through a channel port. Each request names a channel number and says whether it is a write, a read or a count query. The host reaches the block through a small memory-mapped register port.

There are three queues:
- The outbound queue carries messages from the core to the host.
- The outbound interrupt queue does the same and also pulses an interrupt line when it accepts a message.
- The inbound queue carries messages from the host to the core.

The two sides see different flow control. A core request that cannot proceed holds `core_ready` low, and the core keeps the request asserted until it is taken. Host accesses always complete in one cycle. As a result, a host write to a full inbound queue loses data: the new message replaces the newest stored one, and a sticky overrun flag is set. Core read data and host read data both appear registered, one cycle after the access is taken.

Channel numbers:
- 0 is outbound write.
- 1 is outbound-interrupt write.
- 2 is inbound read.
- 3 to 7 are not assigned.

Host register addresses:
- 0 reads the outbound queue.
- 1 reads the outbound interrupt queue.
- 2 writes the inbound queue.
- 3 reads the status word.

Top module: `mbox_chan_unit`

## Requirements
- R1: After reset the outbound and interrupt-queue free counts read 1, the inbound pending count reads 0, the status word reads 0x00000400, and `irq` is low.
- R2: An accepted core write on channel 0 lowers that channel's free count by 1. A host read at address 0 returns that message and raises the free count by 1 again. Status bits [7:0] hold the number of unread outbound messages.
- R3: A core write to a full outbound or interrupt queue holds `core_ready` low until the host reads that queue. The write is then taken and its data is kept.
- R4: Acceptance of a core write on channel 1 drives `irq` high for exactly the one cycle after the accepting edge. Status bits [23:16] hold the number of unread interrupt-queue messages, and host address 1 returns the message.
- R5: The inbound queue holds up to 4 messages and is first-in first-out. A count query on channel 2 returns the number of pending messages, and a core read returns the oldest message.
- R6: A core read of channel 2 while the inbound queue is empty holds `core_ready` low until a host write arrives. The read then returns that message.
- R7: A host write to a full inbound queue never stalls. It replaces the newest stored message, leaves the pending count at 4, and sets status bit 24. That bit stays set until a status read, which returns it as 1 and then clears it.
- R8: A core read, or a count query, on channels 3 to 7 returns 0. A core read of a write-only channel (0 or 1) returns 0. Core writes to channels 2 to 7 change no queue.
- R9: A host read at address 0 or 1 while that queue is empty returns 0xFFFFFFFF and leaves every count unchanged.
- R10: Status bits [15:8] hold the inbound free count, which is 4 minus the pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core request, held until taken |
| core_wr | input | 1 | 1 = channel write, 0 = read |
| core_cnt | input | 1 | 1 = count query on the channel (never stalls) |
| core_chan | input | 3 | Channel number |
| core_wdata | input | 32 | Core write data |
| core_ready | output | 1 | Request taken on this edge when high with `core_req` |
| core_rdata | output | 32 | Registered read or count data |
| core_rvalid | output | 1 | `core_rdata` holds a new result |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_rvalid | output | 1 | `host_rdata` holds a new result |
| irq | output | 1 | One-cycle interrupt pulse toward the host |

## Verification
Several rules are checked by the assertions on every cycle:
- A push never reaches a full outbound queue.
- Each interrupt pulse matches exactly one accepted interrupt-queue write.
- The inbound occupancy stays within bounds.
- A core read of an empty inbound queue is always stalled.
- An empty outbound read returns all ones.
- The overrun flag stays set until a status read.

Only the bench scenarios can show the following:
- Message order and content across the queues.
- That an overrun lands on the newest entry.
- That a stalled request completes with the right data after the host acts.
- That unassigned channels leave every count untouched.

The bench sweeps every inbound fill level from empty to two writes past full.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int CHAN_W = 3;
  localparam int HADDR_W = 2;

  localparam logic [CHAN_W-1:0] CH_OUT     = 3'd0;
  localparam logic [CHAN_W-1:0] CH_OUT_IRQ = 3'd1;
  localparam logic [CHAN_W-1:0] CH_IN      = 3'd2;

  localparam logic [HADDR_W-1:0] HA_OUT     = 2'd0;
  localparam logic [HADDR_W-1:0] HA_OUT_IRQ = 2'd1;
  localparam logic [HADDR_W-1:0] HA_IN      = 2'd2;
  localparam logic [HADDR_W-1:0] HA_STAT    = 2'd3;

  // status word field positions
  localparam int ST_OUT_LSB = 0;
  localparam int ST_IN_LSB  = 8;
  localparam int ST_IRQ_LSB = 16;
  localparam int ST_OVR_BIT = 24;
  localparam int ST_FLD_W   = 8;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  parameter bit OVERWRITE = 1'b0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             ovr
);
  logic [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr, wr_idx;
  logic do_push, do_pop, do_ovw;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign do_ovw  = OVERWRITE & push & full & ~do_pop;
  assign ovr     = do_ovw;
  assign wr_idx  = do_ovw ? ptr_dec(wptr) : wptr;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push || do_ovw) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_inc(wptr);
      if (do_pop)  rptr <= ptr_inc(rptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)); // R5
endmodule

// File: rtl/mbox_core_port.sv
module mbox_core_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_DEPTH = 1,
  parameter int IN_DEPTH = 4,
  localparam int OCNT_W = $clog2(OUT_DEPTH + 1),
  localparam int ICNT_W = $clog2(IN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              core_wr,
  input  logic              core_cnt,
  input  logic [CHAN_W-1:0] core_chan,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_rvalid,
  input  logic              ob_full,
  input  logic              obi_full,
  input  logic              ib_empty,
  input  logic [OCNT_W-1:0] ob_cnt,
  input  logic [OCNT_W-1:0] obi_cnt,
  input  logic [ICNT_W-1:0] ib_cnt,
  input  logic [DATA_W-1:0] ib_rdata,
  output logic              ob_push,
  output logic              obi_push,
  output logic              ib_pop
);
  logic acc, xfer;
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    core_ready = 1'b1;
    if (core_req && !core_cnt) begin
      if (core_wr) begin
        if (core_chan == CH_OUT)          core_ready = ~ob_full;
        else if (core_chan == CH_OUT_IRQ) core_ready = ~obi_full;
      end else if (core_chan == CH_IN) begin
        core_ready = ~ib_empty;
      end
    end
  end

  assign acc      = core_req & core_ready;
  assign xfer     = acc & ~core_cnt;
  assign ob_push  = xfer & core_wr  & (core_chan == CH_OUT);
  assign obi_push = xfer & core_wr  & (core_chan == CH_OUT_IRQ);
  assign ib_pop   = xfer & ~core_wr & (core_chan == CH_IN);

  always_comb begin
    rd_val = '0;
    if (core_cnt) begin
      if (core_chan == CH_OUT)          rd_val = DATA_W'(OUT_DEPTH) - DATA_W'(ob_cnt);
      else if (core_chan == CH_OUT_IRQ) rd_val = DATA_W'(OUT_DEPTH) - DATA_W'(obi_cnt);
      else if (core_chan == CH_IN)      rd_val = DATA_W'(ib_cnt);
    end else if (core_chan == CH_IN) begin
      rd_val = ib_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_rdata  <= '0;
      core_rvalid <= 1'b0;
    end else begin
      core_rvalid <= acc & (core_cnt | ~core_wr);
      if (acc && (core_cnt || !core_wr)) core_rdata <= rd_val;
    end
  end

  AST_IN_EMPTY_STALLS: assert property (@(posedge clk) disable iff (rst)
    (core_req && !core_wr && !core_cnt && core_chan == CH_IN && ib_empty) |-> !core_ready); // R6
endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_DEPTH = 1,
  parameter int IN_DEPTH = 4,
  localparam int OCNT_W = $clog2(OUT_DEPTH + 1),
  localparam int ICNT_W = $clog2(IN_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_en,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic               ob_empty,
  input  logic               obi_empty,
  input  logic [DATA_W-1:0]  ob_rdata,
  input  logic [DATA_W-1:0]  obi_rdata,
  input  logic [OCNT_W-1:0]  ob_cnt,
  input  logic [OCNT_W-1:0]  obi_cnt,
  input  logic [ICNT_W-1:0]  ib_cnt,
  input  logic               ib_ovr,
  output logic               ob_pop,
  output logic               obi_pop,
  output logic               ib_push,
  output logic [DATA_W-1:0]  ib_wdata
);
  logic rd, stat_rd, ovr_flag;
  logic [DATA_W-1:0] status, rd_val;

  assign rd       = host_en & ~host_we;
  assign ob_pop   = rd & (host_addr == HA_OUT);
  assign obi_pop  = rd & (host_addr == HA_OUT_IRQ);
  assign stat_rd  = rd & (host_addr == HA_STAT);
  assign ib_push  = host_en & host_we & (host_addr == HA_IN);
  assign ib_wdata = host_wdata;

  always_comb begin
    status = '0;
    status[ST_OUT_LSB +: ST_FLD_W] = ST_FLD_W'(ob_cnt);
    status[ST_IN_LSB  +: ST_FLD_W] = ST_FLD_W'(IN_DEPTH) - ST_FLD_W'(ib_cnt);
    status[ST_IRQ_LSB +: ST_FLD_W] = ST_FLD_W'(obi_cnt);
    status[ST_OVR_BIT] = ovr_flag;
  end

  always_comb begin
    case (host_addr)
      HA_OUT:     rd_val = ob_empty  ? '1 : ob_rdata;
      HA_OUT_IRQ: rd_val = obi_empty ? '1 : obi_rdata;
      HA_STAT:    rd_val = status;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      ovr_flag    <= 1'b0;
    end else begin
      host_rvalid <= rd;
      if (rd) host_rdata <= rd_val;
      if (ib_ovr)       ovr_flag <= 1'b1;
      else if (stat_rd) ovr_flag <= 1'b0;
    end
  end

  AST_EMPTY_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (ob_pop && ob_empty) |=> (host_rdata == '1)); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !stat_rd) |=> ovr_flag); // R7
endmodule

// File: rtl/mbox_chan_unit.sv
module mbox_chan_unit
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OUT_DEPTH = 1,
  parameter int IN_DEPTH = 4,
  localparam int OCNT_W = $clog2(OUT_DEPTH + 1),
  localparam int ICNT_W = $clog2(IN_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               core_req,
  input  logic               core_wr,
  input  logic               core_cnt,
  input  logic [CHAN_W-1:0]  core_chan,
  input  logic [DATA_W-1:0]  core_wdata,
  output logic               core_ready,
  output logic [DATA_W-1:0]  core_rdata,
  output logic               core_rvalid,
  input  logic               host_en,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               irq
);
  logic ob_push, ob_pop, ob_full, ob_empty, ob_ovr;
  logic obi_push, obi_pop, obi_full, obi_empty, obi_ovr;
  logic ib_push, ib_pop, ib_full, ib_empty, ib_ovr;
  logic [OCNT_W-1:0] ob_cnt, obi_cnt;
  logic [ICNT_W-1:0] ib_cnt;
  logic [DATA_W-1:0] ob_rdata, obi_rdata, ib_rdata, ib_wdata;

  mbox_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH), .OVERWRITE(1'b0)) u_out (
    .clk(clk), .rst(rst), .push(ob_push), .pop(ob_pop), .wdata(core_wdata),
    .rdata(ob_rdata), .count(ob_cnt), .full(ob_full), .empty(ob_empty), .ovr(ob_ovr));

  mbox_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH), .OVERWRITE(1'b0)) u_out_irq (
    .clk(clk), .rst(rst), .push(obi_push), .pop(obi_pop), .wdata(core_wdata),
    .rdata(obi_rdata), .count(obi_cnt), .full(obi_full), .empty(obi_empty), .ovr(obi_ovr));

  mbox_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH), .OVERWRITE(1'b1)) u_in (
    .clk(clk), .rst(rst), .push(ib_push), .pop(ib_pop), .wdata(ib_wdata),
    .rdata(ib_rdata), .count(ib_cnt), .full(ib_full), .empty(ib_empty), .ovr(ib_ovr));

  mbox_core_port #(.DATA_W(DATA_W), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_core (
    .clk(clk), .rst(rst), .core_req(core_req), .core_wr(core_wr), .core_cnt(core_cnt),
    .core_chan(core_chan), .core_ready(core_ready), .core_rdata(core_rdata),
    .core_rvalid(core_rvalid), .ob_full(ob_full), .obi_full(obi_full), .ib_empty(ib_empty),
    .ob_cnt(ob_cnt), .obi_cnt(obi_cnt), .ib_cnt(ib_cnt), .ib_rdata(ib_rdata),
    .ob_push(ob_push), .obi_push(obi_push), .ib_pop(ib_pop));

  mbox_host_port #(.DATA_W(DATA_W), .OUT_DEPTH(OUT_DEPTH), .IN_DEPTH(IN_DEPTH)) u_host (
    .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ob_empty(ob_empty), .obi_empty(obi_empty), .ob_rdata(ob_rdata), .obi_rdata(obi_rdata),
    .ob_cnt(ob_cnt), .obi_cnt(obi_cnt), .ib_cnt(ib_cnt), .ib_ovr(ib_ovr),
    .ob_pop(ob_pop), .obi_pop(obi_pop), .ib_push(ib_push), .ib_wdata(ib_wdata));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= obi_push;
  end

  AST_OUT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ob_push |-> (!ob_full || ob_pop)) && !ob_ovr && !obi_ovr); // R3
  AST_IRQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    obi_push |=> irq); // R4
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(obi_push)); // R4
  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    ib_ovr |-> ib_full); // R7
endmodule

// File: tb/mbox_chan_unit_tb.sv
module mbox_chan_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IN_DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic core_req = 0, core_wr = 0, core_cnt = 0;
  logic [2:0] core_chan = '0;
  logic [31:0] core_wdata = '0;
  logic core_ready, core_rvalid, host_rvalid, irq;
  logic [31:0] core_rdata, host_rdata;
  logic host_en = 0, host_we = 0;
  logic [1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;

  int checks = 0, errors = 0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_chan_unit u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic core_op(input bit wr, input bit cnt, input logic [2:0] ch,
                         input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    core_req = 1; core_wr = wr; core_cnt = cnt; core_chan = ch; core_wdata = d;
    #1;
    while (!core_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    core_req = 0;
    rd = core_rdata;
  endtask

  task automatic host_op(input bit we, input logic [1:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    @(negedge clk);
    host_en = 1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_en = 0;
    rd = host_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    core_op(0, 1, 3'd0, 0, r); chk("R1 out free", r, 32'd1);
    core_op(0, 1, 3'd1, 0, r); chk("R1 irq free", r, 32'd1);
    core_op(0, 1, 3'd2, 0, r); chk("R1 in pending", r, 32'd0);
    host_op(0, 2'd3, 0, r);    chk("R1 status", r, 32'h0000_0400);

    // R9 empty host reads
    host_op(0, 2'd0, 0, r); chk("R9 empty out", r, 32'hFFFF_FFFF);
    host_op(0, 2'd1, 0, r); chk("R9 empty irq mbox", r, 32'hFFFF_FFFF);
    core_op(0, 1, 3'd0, 0, r); chk("R9 out free kept", r, 32'd1);
    host_op(0, 2'd3, 0, r); chk("R9 status kept", r, 32'h0000_0400);

    // R2 outbound round trip
    core_op(1, 0, 3'd0, 32'hCAFE_0001, r);
    core_op(0, 1, 3'd0, 0, r); chk("R2 free after write", r, 32'd0);
    host_op(0, 2'd3, 0, r);    chk("R2 status out count", r, 32'h0000_0401);
    host_op(0, 2'd0, 0, r);    chk("R2 host data", r, 32'hCAFE_0001);
    core_op(0, 1, 3'd0, 0, r); chk("R2 free after host read", r, 32'd1);

    // R3 stall on full outbound
    core_op(1, 0, 3'd0, 32'h1111_0000, r);
    @(negedge clk);
    core_req = 1; core_wr = 1; core_cnt = 0; core_chan = 3'd0; core_wdata = 32'h2222_0000;
    for (int i = 0; i < 3; i++) begin
      #1; chk("R3 stalled", {31'd0, core_ready}, 32'd0);
      @(negedge clk);
    end
    host_en = 1; host_we = 0; host_addr = 2'd0;
    #1; chk("R3 still stalled", {31'd0, core_ready}, 32'd0);
    @(negedge clk);
    host_en = 0;
    chk("R3 first message", host_rdata, 32'h1111_0000);
    #1; chk("R3 released", {31'd0, core_ready}, 32'd1);
    @(negedge clk);
    core_req = 0;
    host_op(0, 2'd0, 0, r); chk("R3 stalled data kept", r, 32'h2222_0000);

    // R4 interrupt mailbox
    core_op(1, 0, 3'd1, 32'hBEEF_0004, r);
    chk("R4 irq high", {31'd0, irq}, 32'd1);
    @(negedge clk);
    chk("R4 irq one cycle", {31'd0, irq}, 32'd0);
    host_op(0, 2'd3, 0, r); chk("R4 status irq count", r, 32'h0001_0400);
    host_op(0, 2'd1, 0, r); chk("R4 host data", r, 32'hBEEF_0004);
    core_op(0, 1, 3'd1, 0, r); chk("R4 free restored", r, 32'd1);

    // R8 unassigned channels
    core_op(1, 0, 3'd5, 32'h5555_5555, r);
    core_op(1, 0, 3'd2, 32'h6666_6666, r);
    for (int ch = 3; ch < 8; ch++) begin
      core_op(0, 0, 3'(ch), 0, r); chk("R8 read unassigned", r, 32'd0);
      core_op(0, 1, 3'(ch), 0, r); chk("R8 count unassigned", r, 32'd0);
    end
    core_op(0, 0, 3'd0, 0, r); chk("R8 read write-only", r, 32'd0);
    core_op(0, 1, 3'd2, 0, r); chk("R8 inbound untouched", r, 32'd0);
    host_op(0, 2'd3, 0, r);    chk("R8 status untouched", r, 32'h0000_0400);

    // R5 R7 R10 sweep of inbound fill levels
    for (int n = 0; n <= IN_DEPTH + 2; n++) begin
      int held;
      held = (n < IN_DEPTH) ? n : IN_DEPTH;
      for (int k = 0; k < n; k++) host_op(1, 2'd2, 32'hA000_0000 + 32'(k), r);
      core_op(0, 1, 3'd2, 0, r); chk("R5 pending count", r, 32'(held));
      host_op(0, 2'd3, 0, r);
      chk("R10 inbound free", {24'd0, r[15:8]}, 32'(IN_DEPTH - held));
      chk("R7 overrun flag", {31'd0, r[24]}, {31'd0, (n > IN_DEPTH)});
      host_op(0, 2'd3, 0, r); chk("R7 flag cleared", {31'd0, r[24]}, 32'd0);
      for (int k = 0; k < held; k++) begin
        logic [31:0] e;
        e = (n > IN_DEPTH && k == IN_DEPTH - 1) ? 32'hA000_0000 + 32'(n - 1)
                                                : 32'hA000_0000 + 32'(k);
        core_op(0, 0, 3'd2, 0, r); chk("R5 order", r, e);
      end
      core_op(0, 1, 3'd2, 0, r); chk("R5 drained", r, 32'd0);
    end

    // R6 stall on empty inbound
    @(negedge clk);
    core_req = 1; core_wr = 0; core_cnt = 0; core_chan = 3'd2;
    #1; chk("R6 stalled", {31'd0, core_ready}, 32'd0);
    @(negedge clk);
    #1; chk("R6 still stalled", {31'd0, core_ready}, 32'd0);
    host_en = 1; host_we = 1; host_addr = 2'd2; host_wdata = 32'h7777_0006;
    @(negedge clk);
    host_en = 0;
    #1; chk("R6 released", {31'd0, core_ready}, 32'd1);
    @(negedge clk);
    core_req = 0;
    chk("R6 data", core_rdata, 32'h7777_0006);
    chk("R6 rvalid", {31'd0, core_rvalid}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule